// File: doc/BRIEF.md
# Power-State Gating and Wake Controller

This block sits beside a network interface controller and decides, from the PCI power state the host has programmed, which of the controller's engines may run. In the full-power state the receive engine, the transmit engine, the bus-master DMA engine and interrupt-status posting are all enabled. In any low-power state those engines are frozen in place. The block never clears their FIFOs, so queued receive frames and pending transmit data survive. When the function comes back to full power, DMA resumes from where it stopped. A one-cycle restart request tells the transmit engine to send any partly transmitted frame again from its start.

While the function is powered down, the block watches three wake-event pulses: magic packet, wakeup frame and link change. If wake signalling is enabled, any of these events sets a sticky wake status bit, and the active-low wake output is then driven. Software clears the status by writing 1 to it. An isolate input, when driven low, shuts the controller off completely.

The block also supplies the read value of the power-management capability word. It hides the cold-state wake bit and the auxiliary-current field unless two conditions hold: a configuration bit loaded after reset allows them, and auxiliary power is present.

Top module: `pm_wake_ctrl`

## Requirements
- R1: With `pwr_state` = 2'b00 (D0) and `isolate_n` high, `rx_en`, `tx_en`, `dma_en` and `isr_upd_en` are all 1 from the first clock edge that samples those inputs.
- R2: With any non-zero `pwr_state` (01 = D1, 10 = D2, 11 = D3), all four engine enables are 0 from the first clock edge that samples that state.
- R3: On the first edge that samples `pwr_state` = 00 after an edge that sampled a non-zero state (with `isolate_n` high), `tx_restart` is 1 for exactly one cycle, the same cycle in which the enables return to 1. It is 0 at every other time.
- R4: In a non-D0 state with `pme_en` = 1 and `isolate_n` high, a pulse on any of `wake_magic`, `wake_frame` or `wake_link` sets `pme_sts` at the next edge, and `pme_n` goes low in that same cycle.
- R5: With `pme_en` = 0, wake pulses do not set `pme_sts`, and `pme_n` stays high.
- R6: Wake pulses in D0 do not set `pme_sts`. `pme_n` is high in D0 even while `pme_sts` is 1.
- R7: `pme_sts` is sticky: it stays 1 until a cycle with `pme_sts_clr` = 1 (a write of 1) is sampled, after which it is 0 and `pme_n` is high.
- R8: The configuration bit `cfg_d3c_pme` is captured at the first clock after reset release. If the captured bit is 1 and `aux_present` is 1, `pmc_rd` equals the base word (default 16'hC1C2). Otherwise bits 15 and 8:6 of `pmc_rd` read 0, and every other bit keeps its base value (default 16'h4002).
- R9: While `isolate_n` is low, all engine enables are 0, `pme_n` is high, and wake pulses do not set `pme_sts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | Power state code, 00 = D0 up to 11 = D3 |
| pme_en | input | 1 | Wake signalling enable |
| pme_sts_clr | input | 1 | Write-1 strobe clearing the wake status |
| wake_magic | input | 1 | Magic packet detected pulse |
| wake_frame | input | 1 | Wakeup frame matched pulse |
| wake_link | input | 1 | Link state changed pulse |
| aux_present | input | 1 | Auxiliary power is present |
| cfg_d3c_pme | input | 1 | Configuration bit: wake supported from D3cold |
| isolate_n | input | 1 | Low disables the controller |
| rx_en | output | 1 | Receive engine enable |
| tx_en | output | 1 | Transmit engine enable |
| dma_en | output | 1 | Bus-master DMA enable |
| isr_upd_en | output | 1 | Interrupt status update enable |
| tx_restart | output | 1 | One-cycle request to resend a partly sent frame |
| pme_sts | output | 1 | Sticky wake status |
| pme_n | output | 1 | Active-low wake output |
| pmc_rd | output | 16 | Capability word read value |

## Verification
A wrong gating register shows at the engine enables one edge after the power state changes. A missing or stretched restart shows as a `tx_restart` that is absent or lasts longer than one cycle in the cycle after return to D0. A corrupted wake status shows at `pme_sts` and `pme_n` one edge after a wake pulse or a clear strobe. A wrong captured configuration bit shows in `pmc_rd` as soon as the first clock after reset has passed.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int PS_W = 2;
  typedef enum logic [PS_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;
  localparam int CAP_W = 16;
  localparam int CAP_D3C_BIT = 15;
  localparam int CAP_AUX_LO = 6;
  localparam int CAP_AUX_HI = 8;
endpackage

// File: rtl/pm_engine_gate.sv
module pm_engine_gate
  import pm_wake_pkg::*;
#(
  parameter int N_EN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] pwr_state,
  input  logic            isolate_n,
  output logic [N_EN-1:0] en,
  output logic            tx_restart
);
  logic pd_now;
  logic pd_q, pd_d;
  logic en_q, en_d;
  logic rs_q, rs_d;

  assign pd_now = (pstate_e'(pwr_state) != PS_D0);

  always_comb begin
    pd_d = pd_now;
    en_d = !pd_now && isolate_n;
    rs_d = pd_q && !pd_now && isolate_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
      en_q <= 1'b0;
      rs_q <= 1'b0;
    end else begin
      pd_q <= pd_d;
      en_q <= en_d;
      rs_q <= rs_d;
    end
  end

  for (genvar i = 0; i < N_EN; i++) begin : g_en
    assign en[i] = en_q;
  end
  assign tx_restart = rs_q;

  AST_PD_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_now || !isolate_n) |=> (en == '0)); // R2
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_restart |=> !tx_restart); // R3
  AST_RESTART_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_restart |-> en[0]); // R3
endmodule

// File: rtl/pm_wake_status.sv
module pm_wake_status
  import pm_wake_pkg::*;
#(
  parameter int N_WAKE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PS_W-1:0]   pwr_state,
  input  logic              pme_en,
  input  logic              sts_clr,
  input  logic [N_WAKE-1:0] wake,
  input  logic              isolate_n,
  output logic              sts,
  output logic              pme_n
);
  logic pd_now;
  logic hit;
  logic sts_q, sts_d;

  assign pd_now = (pstate_e'(pwr_state) != PS_D0);
  assign hit = (|wake) && pd_now && pme_en && isolate_n;

  always_comb begin
    sts_d = sts_q;
    if (sts_clr) sts_d = 1'b0;
    if (hit)     sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  assign sts   = sts_q;
  assign pme_n = !(sts_q && pd_now && isolate_n);

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !sts_clr) |=> sts_q); // R7
  AST_NO_SET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_q && !pme_en) |=> !sts_q); // R5
  AST_NO_PME_IN_D0: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_now) |-> pme_n); // R6
  AST_NO_PME_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!isolate_n) |-> pme_n); // R9
endmodule

// File: rtl/pm_cap_word.sv
module pm_cap_word
  import pm_wake_pkg::*;
#(
  parameter logic [CAP_W-1:0] CAP_BASE = 16'hC1C2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bit,
  input  logic             aux_present,
  output logic [CAP_W-1:0] cap_rd
);
  localparam logic [CAP_W-1:0] AUX_MASK =
    (CAP_W'(1) << CAP_D3C_BIT) |
    (((CAP_W'(1) << (CAP_AUX_HI - CAP_AUX_LO + 1)) - CAP_W'(1)) << CAP_AUX_LO);

  logic cfg_q, cfg_d;
  logic ld_q, ld_d;
  logic keep;

  always_comb begin
    cfg_d = cfg_q;
    ld_d  = 1'b1;
    if (!ld_q) cfg_d = cfg_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 1'b0;
      ld_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ld_q  <= ld_d;
    end
  end

  assign keep   = cfg_q && aux_present;
  assign cap_rd = keep ? CAP_BASE : (CAP_BASE & ~AUX_MASK);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |=> $stable(cfg_q)); // R8
  AST_MASKED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_present |-> ((cap_rd & AUX_MASK) == '0)); // R8
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter logic [15:0] CAP_BASE = 16'hC1C2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  pwr_state,
  input  logic        pme_en,
  input  logic        pme_sts_clr,
  input  logic        wake_magic,
  input  logic        wake_frame,
  input  logic        wake_link,
  input  logic        aux_present,
  input  logic        cfg_d3c_pme,
  input  logic        isolate_n,
  output logic        rx_en,
  output logic        tx_en,
  output logic        dma_en,
  output logic        isr_upd_en,
  output logic        tx_restart,
  output logic        pme_sts,
  output logic        pme_n,
  output logic [15:0] pmc_rd
);
  localparam int N_EN = 4;
  localparam int N_WAKE = 3;

  logic [N_EN-1:0] en;

  pm_engine_gate #(.N_EN(N_EN)) u_gate (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .isolate_n(isolate_n),
    .en(en), .tx_restart(tx_restart)
  );

  assign rx_en      = en[0];
  assign tx_en      = en[1];
  assign dma_en     = en[2];
  assign isr_upd_en = en[3];

  pm_wake_status #(.N_WAKE(N_WAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .pme_en(pme_en),
    .sts_clr(pme_sts_clr), .wake({wake_link, wake_frame, wake_magic}),
    .isolate_n(isolate_n), .sts(pme_sts), .pme_n(pme_n)
  );

  pm_cap_word #(.CAP_BASE(CAP_BASE)) u_cap (
    .clk(clk), .rst_n(rst_n), .cfg_bit(cfg_d3c_pme), .aux_present(aux_present),
    .cap_rd(pmc_rd)
  );
endmodule

// File: tb/pm_wake_ctrl_tb.sv
module pm_wake_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] pwr_state;
  logic pme_en, pme_sts_clr, wake_magic, wake_frame, wake_link;
  logic aux_present, cfg_d3c_pme, isolate_n;
  logic rx_en, tx_en, dma_en, isr_upd_en, tx_restart, pme_sts, pme_n;
  logic [15:0] pmc_rd;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pm_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .pme_en(pme_en),
    .pme_sts_clr(pme_sts_clr), .wake_magic(wake_magic), .wake_frame(wake_frame),
    .wake_link(wake_link), .aux_present(aux_present), .cfg_d3c_pme(cfg_d3c_pme),
    .isolate_n(isolate_n), .rx_en(rx_en), .tx_en(tx_en), .dma_en(dma_en),
    .isr_upd_en(isr_upd_en), .tx_restart(tx_restart), .pme_sts(pme_sts),
    .pme_n(pme_n), .pmc_rd(pmc_rd)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge; sample at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; pwr_state = 2'b00; pme_en = 1'b0; pme_sts_clr = 1'b0;
    wake_magic = 1'b0; wake_frame = 1'b0; wake_link = 1'b0;
    aux_present = 1'b1; isolate_n = 1'b1; cfg_d3c_pme = strap;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
    cfg_d3c_pme = ~strap;
  endtask

  function automatic logic [3:0] ens();
    return {rx_en, tx_en, dma_en, isr_upd_en};
  endfunction

  task automatic t_reset_d0();
    chk(ens() == 4'hF, "R1 reset D0 enables", 16'(ens()), 16'hF);
    chk(pme_n && !pme_sts && !tx_restart, "R1 reset idle outputs", {13'd0, pme_n, pme_sts, tx_restart}, 16'h4);
  endtask

  task automatic t_pd_restart(input logic [1:0] st);
    pwr_state = st;
    step();
    chk(ens() == 4'h0, "R2 enables off in power-down", 16'(ens()), 16'h0);
    chk(!tx_restart, "R3 no restart while down", 16'(tx_restart), 16'h0);
    pwr_state = 2'b00;
    step();
    chk(tx_restart && ens() == 4'hF, "R3 restart with enables on return", {11'd0, tx_restart, ens()}, 16'h1F);
    step();
    chk(!tx_restart && ens() == 4'hF, "R3 restart lasts one cycle", {11'd0, tx_restart, ens()}, 16'hF);
  endtask

  task automatic t_wake(input int which);
    pwr_state = 2'b11; pme_en = 1'b1;
    step();
    chk(pme_n && !pme_sts, "R4 idle before wake", {14'd0, pme_n, pme_sts}, 16'h2);
    wake_magic = (which == 0); wake_frame = (which == 1); wake_link = (which == 2);
    step();
    wake_magic = 1'b0; wake_frame = 1'b0; wake_link = 1'b0;
    chk(pme_sts && !pme_n, "R4 wake sets status and drives PME", {14'd0, pme_n, pme_sts}, 16'h1);
    repeat (3) step();
    chk(pme_sts && !pme_n, "R7 status sticky", {14'd0, pme_n, pme_sts}, 16'h1);
    pme_sts_clr = 1'b1;
    step();
    pme_sts_clr = 1'b0;
    chk(!pme_sts && pme_n, "R7 write-1 clears", {14'd0, pme_n, pme_sts}, 16'h2);
    pwr_state = 2'b00; pme_en = 1'b0;
    step();
  endtask

  task automatic t_pme_disabled();
    pwr_state = 2'b01; pme_en = 1'b0;
    step();
    wake_link = 1'b1;
    step();
    wake_link = 1'b0;
    chk(!pme_sts && pme_n, "R5 wake ignored when disabled", {14'd0, pme_n, pme_sts}, 16'h2);
    pwr_state = 2'b00;
    step();
  endtask

  task automatic t_d0();
    pwr_state = 2'b00; pme_en = 1'b1;
    wake_magic = 1'b1;
    step();
    wake_magic = 1'b0;
    chk(!pme_sts && pme_n, "R6 wake ignored in D0", {14'd0, pme_n, pme_sts}, 16'h2);
    pwr_state = 2'b10; wake_frame = 1'b1;
    step();
    wake_frame = 1'b0;
    chk(pme_sts && !pme_n, "R4 set in D2", {14'd0, pme_n, pme_sts}, 16'h1);
    pwr_state = 2'b00;
    #1;
    chk(pme_sts && pme_n, "R6 no PME in D0 with status set", {14'd0, pme_n, pme_sts}, 16'h3);
    step();
    pme_sts_clr = 1'b1;
    step();
    pme_sts_clr = 1'b0; pme_en = 1'b0;
  endtask

  task automatic t_isolate();
    pme_en = 1'b1; pwr_state = 2'b11;
    step();
    isolate_n = 1'b0; wake_magic = 1'b1;
    step();
    wake_magic = 1'b0;
    chk(!pme_sts && pme_n, "R9 isolate blocks wake", {14'd0, pme_n, pme_sts}, 16'h2);
    pwr_state = 2'b00;
    step();
    chk(ens() == 4'h0 && !tx_restart, "R9 isolate holds enables off", {11'd0, tx_restart, ens()}, 16'h0);
    isolate_n = 1'b1; pme_en = 1'b0;
    step();
    chk(ens() == 4'hF, "R1 enables back after isolate", 16'(ens()), 16'hF);
  endtask

  task automatic t_cap();
    do_reset(1'b1);
    aux_present = 1'b1; #1;
    chk(pmc_rd == 16'hC1C2, "R8 strap1 aux on", pmc_rd, 16'hC1C2);
    aux_present = 1'b0; #1;
    chk(pmc_rd == 16'h4002, "R8 strap1 aux off", pmc_rd, 16'h4002);
    do_reset(1'b0);
    aux_present = 1'b1; #1;
    chk(pmc_rd == 16'h4002, "R8 strap0 aux on", pmc_rd, 16'h4002);
  endtask

  initial begin
    do_reset(1'b1);
    t_reset_d0();
    t_pd_restart(2'b01);
    t_pd_restart(2'b11);
    t_wake(0);
    t_wake(1);
    t_wake(2);
    t_pme_disabled();
    t_d0();
    t_isolate();
    t_cap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule